// File: doc/BRIEF.md
# Block-Mean Motion Map Generator

This block turns a stream of 8-bit pixels, delivered one region at a time, into a coarse motion map of a whole scene. It never holds a full-resolution frame. Each rectangular region is reduced while it streams in. Every small pixel block inside the region becomes one averaged cell, and that cell is placed into a low-resolution observation grid at the position that matches the region's place in a sweep of regions. When the last region of a sweep arrives, every cell has been compared against its value from the sweep before. The per-cell absolute changes then pass through a small separable blur and leave the block as one raster-ordered frame.

In the default configuration a region is 64 pixels wide and 40 pixels tall. It is cut into 8 by 8 cells, so each cell averages a block 8 pixels wide and 5 rows tall. A sweep covers a grid of regions 5 across and 6 down, which gives an observation grid 40 cells wide and 48 cells tall. The observation grid needs only one store, because each cell's earlier value is read out in the same cycle that its new value is written. The per-cell change map is kept in two banks: one bank fills during a sweep while the other is read out for smoothing.

Top module: `motion_map_gen`

## Requirements
- R1: While reset is held, and after reset until the first sweep has been fully delivered, `map_valid` stays low.
- R2: Pixels count only in cycles where `pix_valid` is high.
  - Within a region, pixels arrive row by row, left to right.
  - Regions arrive row-major across the sweep grid.
  - The pixel at region column `rc`, region row `rr` and in-region position (x, y) feeds map cell column `rc*CELLS_X + x/BLK_W` and map row `rr*CELLS_Y + y/BLK_H`.
- R3: Each cell value is floor(block sum / (BLK_W*BLK_H)) and is exact over the whole input range. A block of all-255 pixels gives 255.
- R4: The frame produced after the first sweep following reset is all zero.
- R5: From the second sweep on, the change of a cell is |new mean - previous sweep's mean|. It is exact whichever of the two values is larger.
- R6: The output value at each map position is floor(S/16), where S is a weighted sum of the 3 by 3 neighbourhood of change values.
  - The weight is the product of a row factor and a column factor.
  - Each factor is 2 on the centre line of the neighbourhood and 1 on either side of it.
- R7: Neighbours that fall outside the map take the value of the nearest edge cell in that direction.
- R8: After each sweep, exactly MAP_W*MAP_H values leave the block.
  - They come out row by row from the top, and left to right within a row.
  - Each value is marked by a one-cycle `map_valid` pulse, and no two pulses are adjacent.
  - `map_last` is high with the final value only.
- R9: When a sweep repeats the previous sweep's pixels, the whole frame is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| pix_valid | input | 1 | Qualifies `pix_data` this cycle |
| pix_data | input | PIX_W | Pixel intensity |
| map_valid | output | 1 | One smoothed map value is present |
| map_data | output | PIX_W | Smoothed motion value |
| map_last | output | 1 | Marks the final value of a frame |

## Verification
Each sweep uses one pattern, and each pattern separates a different fault.

- **Repeated ramp.** A ramp sent twice separates a correct first-sweep clear from a map that keeps stale content.
- **Single bright block, then removed.** A bright block in an interior cell shows the blur footprint and confirms where the cell lands, which catches swapped coordinates. Taking the block away again shows that the difference is absolute.
- **Corner block.** A bright block in the corner cell is spread only through edge replication.
- **Full-scale steps and a product pattern.** All-255 followed by all-0 pushes the mean, the difference and the blur to full range. A product pattern gives block sums that are not multiples of the divisor, so it checks the floor division.

Input stalls are spread through every sweep.

// File: rtl/motion_map_pkg.sv
package motion_map_pkg;

  // Reciprocal of divisor, rounded up, scaled by 2^shift.
  function automatic logic [63:0] recip_of(int unsigned divisor, int unsigned shift);
    logic [63:0] one;
    one = 64'd1 << shift;
    return (one + 64'(divisor) - 64'd1) / 64'(divisor);
  endfunction

  // Floor division realised as multiply and shift.
  function automatic logic [63:0] scaled_quot(logic [63:0] total, logic [63:0] recip,
                                              int unsigned shift);
    return (total * recip) >> shift;
  endfunction

  function automatic logic [15:0] abs_gap(logic [15:0] a, logic [15:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  // Separable 1-2-1 weight; row/col index 0..2, centre is 1.
  function automatic logic [2:0] kernel_weight(logic [1:0] r, logic [1:0] c);
    logic [2:0] wr;
    logic [2:0] wc;
    wr = (r == 2'd1) ? 3'd2 : 3'd1;
    wc = (c == 2'd1) ? 3'd2 : 3'd1;
    return 3'(wr * wc);
  endfunction

  // Neighbour coordinate with edge replication; step 0:-1, 1:0, 2:+1.
  function automatic logic [15:0] clamp_step(logic [15:0] pos, logic [1:0] step,
                                             logic [15:0] last);
    if (step == 2'd0) return (pos == 16'd0) ? pos : pos - 16'd1;
    if (step == 2'd2) return (pos == last) ? pos : pos + 16'd1;
    return pos;
  endfunction

endpackage

// File: rtl/motion_map_accum.sv
module motion_map_accum
  import motion_map_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int REG_W   = 64,
  parameter int REG_H   = 40,
  parameter int CELLS_X = 8,
  parameter int CELLS_Y = 8,
  parameter int GRID_C  = 5,
  parameter int GRID_R  = 6,
  parameter int ADDR_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              cell_wr,
  output logic [ADDR_W-1:0] cell_addr,
  output logic [PIX_W-1:0]  cell_mean,
  output logic              sweep_done
);
  localparam int BLK_W = REG_W / CELLS_X;
  localparam int BLK_H = REG_H / CELLS_Y;
  localparam int BLK_N = BLK_W * BLK_H;
  localparam int SUM_W = PIX_W + $clog2(BLK_N);
  localparam int MAP_W = CELLS_X * GRID_C;
  localparam int MAP_N = MAP_W * CELLS_Y * GRID_R;
  localparam int unsigned SHIFT = SUM_W + $clog2(BLK_N) + 1;
  localparam logic [63:0] RECIP = recip_of(BLK_N, SHIFT);
  localparam int PXW = (BLK_W > 1) ? $clog2(BLK_W) : 1;
  localparam int PYW = (BLK_H > 1) ? $clog2(BLK_H) : 1;
  localparam int CXW = (CELLS_X > 1) ? $clog2(CELLS_X) : 1;
  localparam int CYW = (CELLS_Y > 1) ? $clog2(CELLS_Y) : 1;
  localparam int RCW = (GRID_C > 1) ? $clog2(GRID_C) : 1;
  localparam int RRW = (GRID_R > 1) ? $clog2(GRID_R) : 1;

  logic [PXW-1:0] px;
  logic [PYW-1:0] py;
  logic [CXW-1:0] cx;
  logic [CYW-1:0] cy;
  logic [RCW-1:0] rc;
  logic [RRW-1:0] rr;

  logic at_px_end, at_row_end, at_band_row, at_band_end;
  logic at_region_end, at_gridrow_end, at_sweep_end;

  assign at_px_end      = (px == PXW'(BLK_W - 1));
  assign at_row_end     = at_px_end && (cx == CXW'(CELLS_X - 1));
  assign at_band_row    = (py == PYW'(BLK_H - 1));
  assign at_band_end    = at_row_end && at_band_row;
  assign at_region_end  = at_band_end && (cy == CYW'(CELLS_Y - 1));
  assign at_gridrow_end = at_region_end && (rc == RCW'(GRID_C - 1));
  assign at_sweep_end   = at_gridrow_end && (rr == RRW'(GRID_R - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px <= '0; py <= '0; cx <= '0; cy <= '0; rc <= '0; rr <= '0;
    end else if (pix_valid) begin
      px <= at_px_end ? '0 : px + 1'b1;
      if (at_px_end)      cx <= at_row_end ? '0 : cx + 1'b1;
      if (at_row_end)     py <= at_band_row ? '0 : py + 1'b1;
      if (at_band_end)    cy <= at_region_end ? '0 : cy + 1'b1;
      if (at_region_end)  rc <= at_gridrow_end ? '0 : rc + 1'b1;
      if (at_gridrow_end) rr <= at_sweep_end ? '0 : rr + 1'b1;
    end
  end

  // One running sum per cell column of the current band.
  logic [SUM_W-1:0] acc [CELLS_X];
  logic [SUM_W-1:0] pix_ext, cur_acc, cell_total;
  logic             cell_first;

  assign pix_ext    = SUM_W'(pix_data);
  assign cell_first = (px == '0) && (py == '0);

  for (genvar i = 0; i < CELLS_X; i++) begin : g_acc
    logic [SUM_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (pix_valid && (cx == CXW'(i)))
        q <= cell_first ? pix_ext : q + pix_ext;
    end
    assign acc[i] = q;
  end

  assign cur_acc    = acc[cx];
  assign cell_total = cur_acc + pix_ext;
  assign cell_mean  = PIX_W'(scaled_quot(64'(cell_total), RECIP, SHIFT));
  assign cell_wr    = pix_valid && at_px_end && at_band_row;
  assign cell_addr  = ADDR_W'((int'(rr) * CELLS_Y + int'(cy)) * MAP_W
                              + int'(rc) * CELLS_X + int'(cx));
  assign sweep_done = pix_valid && at_sweep_end;

  // R2
  cell_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_wr |-> (int'(cell_addr) < MAP_N));

  // R2
  sweep_closes_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> cell_wr);

endmodule

// File: rtl/motion_map_store.sv
module motion_map_store
  import motion_map_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int MAP_N  = 1920,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PIX_W-1:0]  wr_mean,
  input  logic              sweep_done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PIX_W-1:0]  rd_diff
);
  logic [PIX_W-1:0] obs   [MAP_N];
  logic [PIX_W-1:0] gap_a [MAP_N];
  logic [PIX_W-1:0] gap_b [MAP_N];
  logic             fill_b;
  logic             primed;
  logic [PIX_W-1:0] old_mean, new_gap;

  assign old_mean = obs[wr_addr];
  assign new_gap  = primed ? PIX_W'(abs_gap(16'(wr_mean), 16'(old_mean))) : '0;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      obs[wr_addr] <= wr_mean;
      if (fill_b) gap_b[wr_addr] <= new_gap;
      else        gap_a[wr_addr] <= new_gap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_b <= 1'b0;
      primed <= 1'b0;
    end else if (sweep_done) begin
      fill_b <= ~fill_b;
      primed <= 1'b1;
    end
  end

  // The bank not being filled holds the last complete change map.
  assign rd_diff = fill_b ? gap_a[rd_addr] : gap_b[rd_addr];

  // R4
  primed_after_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> primed);

  // R8
  bank_swaps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> (fill_b != $past(fill_b)));

endmodule

// File: rtl/motion_map_smooth.sv
module motion_map_smooth
  import motion_map_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int MAP_W  = 40,
  parameter int MAP_H  = 48,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_diff,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_data,
  output logic              out_last
);
  localparam int ACC_W = PIX_W + 4;
  localparam int XW = (MAP_W > 1) ? $clog2(MAP_W) : 1;
  localparam int YW = (MAP_H > 1) ? $clog2(MAP_H) : 1;
  localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(16 * ((1 << PIX_W) - 1));

  logic             busy;
  logic [XW-1:0]    ox;
  logic [YW-1:0]    oy;
  logic [1:0]       tr, tc;
  logic [ACC_W-1:0] acc, acc_next;
  logic [15:0]      nx, ny;
  logic             last_tap, last_col, last_px;

  assign nx       = clamp_step(16'(ox), tc, 16'(MAP_W - 1));
  assign ny       = clamp_step(16'(oy), tr, 16'(MAP_H - 1));
  assign rd_addr  = ADDR_W'(int'(ny) * MAP_W + int'(nx));
  assign acc_next = acc + ACC_W'(kernel_weight(tr, tc)) * ACC_W'(rd_diff);
  assign last_tap = (tr == 2'd2) && (tc == 2'd2);
  assign last_col = (ox == XW'(MAP_W - 1));
  assign last_px  = last_col && (oy == YW'(MAP_H - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ox <= '0; oy <= '0; tr <= '0; tc <= '0; acc <= '0;
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (start) begin
        busy <= 1'b1; ox <= '0; oy <= '0; tr <= '0; tc <= '0; acc <= '0;
      end else if (busy) begin
        if (tc == 2'd2) begin
          tc <= '0;
          tr <= last_tap ? 2'd0 : tr + 2'd1;
        end else begin
          tc <= tc + 2'd1;
        end
        if (last_tap) begin
          acc       <= '0;
          out_valid <= 1'b1;
          out_data  <= PIX_W'(acc_next >> 4);
          out_last  <= last_px;
          if (last_col) begin
            ox   <= '0;
            oy   <= last_px ? '0 : oy + 1'b1;
            busy <= !last_px;
          end else begin
            ox <= ox + 1'b1;
          end
        end else begin
          acc <= acc_next;
        end
      end
    end
  end

  // R8
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R8
  beat_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (acc <= ACC_MAX));

endmodule

// File: rtl/motion_map_gen.sv
module motion_map_gen #(
  parameter int PIX_W   = 8,
  parameter int REG_W   = 64,
  parameter int REG_H   = 40,
  parameter int CELLS_X = 8,
  parameter int CELLS_Y = 8,
  parameter int GRID_C  = 5,
  parameter int GRID_R  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             map_valid,
  output logic [PIX_W-1:0] map_data,
  output logic             map_last
);
  localparam int MAP_W  = CELLS_X * GRID_C;
  localparam int MAP_H  = CELLS_Y * GRID_R;
  localparam int MAP_N  = MAP_W * MAP_H;
  localparam int ADDR_W = (MAP_N > 1) ? $clog2(MAP_N) : 1;

  logic              cell_wr;
  logic [ADDR_W-1:0] cell_addr;
  logic [PIX_W-1:0]  cell_mean;
  logic              sweep_done;
  logic [ADDR_W-1:0] rd_addr;
  logic [PIX_W-1:0]  rd_diff;

  motion_map_accum #(
    .PIX_W(PIX_W), .REG_W(REG_W), .REG_H(REG_H), .CELLS_X(CELLS_X),
    .CELLS_Y(CELLS_Y), .GRID_C(GRID_C), .GRID_R(GRID_R), .ADDR_W(ADDR_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .cell_wr(cell_wr), .cell_addr(cell_addr), .cell_mean(cell_mean),
    .sweep_done(sweep_done)
  );

  motion_map_store #(
    .PIX_W(PIX_W), .MAP_N(MAP_N), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(cell_wr), .wr_addr(cell_addr),
    .wr_mean(cell_mean), .sweep_done(sweep_done), .rd_addr(rd_addr),
    .rd_diff(rd_diff)
  );

  motion_map_smooth #(
    .PIX_W(PIX_W), .MAP_W(MAP_W), .MAP_H(MAP_H), .ADDR_W(ADDR_W)
  ) u_smooth (
    .clk(clk), .rst_n(rst_n), .start(sweep_done), .rd_addr(rd_addr),
    .rd_diff(rd_diff), .out_valid(map_valid), .out_data(map_data),
    .out_last(map_last)
  );

  // R1
  no_output_in_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !map_valid);

endmodule

// File: tb/motion_map_gen_test.sv
module motion_map_gen_test;
  localparam int RW = 16, RH = 10, CX = 2, CY = 2, GC = 3, GR = 2;
  localparam int BW = RW / CX, BH = RH / CY;
  localparam int MW = CX * GC, MH = CY * GR, MN = MW * MH;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = 8'd0;
  logic       map_valid, map_last;
  logic [7:0] map_data;

  motion_map_gen #(
    .PIX_W(8), .REG_W(RW), .REG_H(RH), .CELLS_X(CX), .CELLS_Y(CY),
    .GRID_C(GC), .GRID_R(GR)
  ) uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .map_valid(map_valid), .map_data(map_data), .map_last(map_last)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int got = 0;
  int cap_v [64];
  int cap_l [64];
  int prev_obs [MN];
  int cur_obs [MN];
  int motion [MN];
  int expv [MN];
  bit primed_m = 1'b0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (map_valid) begin
      if (got < 64) begin
        cap_v[got] = int'(map_data);
        cap_l[got] = int'(map_last);
      end
      got++;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pixval(int mode, int gx, int gy);
    int base;
    base = (gx * 7 + gy * 13 + 3) % 256;
    case (mode)
      1: return (gx / BW == 2 && gy / BH == 1) ? 250 : base;
      2: return (gx / BW == 0 && gy / BH == 0) ? 255 : base;
      3: return 255;
      4: return 0;
      5: return (gx * gy + gx * 3 + gy) % 256;
      default: return base;
    endcase
  endfunction

  task automatic build_expected(int mode);
    for (int my = 0; my < MH; my++)
      for (int mx = 0; mx < MW; mx++) begin
        int sum;
        sum = 0;
        for (int j = 0; j < BH; j++)
          for (int i = 0; i < BW; i++)
            sum += pixval(mode, mx * BW + i, my * BH + j);
        cur_obs[my * MW + mx] = sum / (BW * BH);
      end
    for (int k = 0; k < MN; k++) begin
      int d;
      d = cur_obs[k] - prev_obs[k];
      motion[k] = primed_m ? ((d < 0) ? -d : d) : 0;
    end
    for (int y = 0; y < MH; y++)
      for (int x = 0; x < MW; x++) begin
        int s;
        s = 0;
        for (int dy = -1; dy <= 1; dy++)
          for (int dx = -1; dx <= 1; dx++) begin
            int yy, xx, w;
            yy = y + dy; xx = x + dx;
            if (yy < 0) yy = 0;
            if (yy > MH - 1) yy = MH - 1;
            if (xx < 0) xx = 0;
            if (xx > MW - 1) xx = MW - 1;
            w = ((dy == 0) ? 2 : 1) * ((dx == 0) ? 2 : 1);
            s += w * motion[yy * MW + xx];
          end
        expv[y * MW + x] = s / 16;
      end
  endtask

  task automatic drive_sweep(int mode);
    int n;
    n = 0;
    for (int rr = 0; rr < GR; rr++)
      for (int rc = 0; rc < GC; rc++)
        for (int y = 0; y < RH; y++)
          for (int x = 0; x < RW; x++) begin
            bit lastp;
            lastp = (rr == GR - 1) && (rc == GC - 1) && (y == RH - 1) && (x == RW - 1);
            if (n % 7 == 3) begin
              @(negedge clk);
              pix_valid = 1'b0;
              pix_data  = 8'hA5;
            end
            @(negedge clk);
            if (lastp) check("R8", "no beat before sweep end", got, 0);
            pix_valid = 1'b1;
            pix_data  = 8'(pixval(mode, rc * RW + x, rr * RH + y));
            n++;
          end
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic run_frame(int mode, string req);
    got = 0;
    build_expected(mode);
    drive_sweep(mode);
    repeat (MN * 9 + 40) @(negedge clk);
    check("R8", "beat count", got, MN);
    for (int k = 0; k < MN; k++) begin
      check(req, $sformatf("mode %0d cell %0d", mode, k), cap_v[k], expv[k]);
      check("R8", $sformatf("last flag beat %0d", k), cap_l[k], int'(k == MN - 1));
    end
    prev_obs = cur_obs;
    primed_m = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1", "valid low in reset", int'(map_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "valid low after reset", int'(map_valid), 0);
    run_frame(0, "R4");
    run_frame(0, "R9");
    run_frame(1, "R2 R5 R6");
    run_frame(0, "R5");
    run_frame(2, "R7");
    run_frame(3, "R3");
    run_frame(4, "R3 R5");
    run_frame(5, "R3 R6");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule